// File: doc/BRIEF.md
# PS/2 Device Transmit Engine

This block is the sending half of the device end of a PS/2 link. An upstream byte source hands it one byte over a ready/valid handshake. The block sends that byte to the host as an 11-bit serial frame and generates every link clock pulse itself. Both link wires are open-drain. The block sees each wire through a sampled input and pulls it down through a separate drive-low enable. A parameter sets the length of each clock half-period in system-clock cycles.

Before it starts, the block waits for the link to be free. Both wires must have been seen high for a full half-period. A host holding the clock low (inhibit) or holding data low with the clock high (request-to-send) keeps the block waiting. During every released clock phase, the block watches the clock wire for the host pulling it low. If that happens before the tenth clock has risen, the block lets go of both wires, keeps the byte, and sends it again from the start once the link is free. Contention that comes later than that is ignored, and the frame completes. Each attempt ends with a one-cycle done or aborted pulse.

Top module: `ps2_dev_tx`

## Requirements
- R1: After reset both drive-low enables are off, `tx_ready` is 1, and `busy`, `done` and `aborted` are 0.
- R2: A byte is taken when `tx_valid` and `tx_ready` are both high at a clock edge. From the next cycle, `tx_ready` stays 0 until the `done` pulse of that byte, including across any number of aborted attempts.
- R3: A frame starts only after the synchronised CLK and DATA inputs have both been high for HALF_CYC consecutive cycles. While the host holds CLK low, nothing is driven. `busy` rises between HALF_CYC and HALF_CYC+4 cycles after the host releases the line.
- R4: While DATA is held low by the host and CLK is high (request-to-send), no frame starts and CLK is not driven.
- R5: A frame has exactly 11 falling CLK edges. The DATA values at those edges are, in order: 0; the byte's bits 0 to 7, LSB first; an odd-parity bit, which makes the count of ones over the data and parity odd; and 1. A released DATA wire reads 1 and a driven one reads 0.
- R6: Every CLK low phase and every released high phase inside a frame lasts exactly HALF_CYC cycles.
- R7: DATA never changes while CLK is driven low, and never in the cycle in which CLK is released. It changes at the middle of a high phase.
- R8: If the host pulls CLK low during any high phase that comes before clock 10 or 11, both wires are released within 4 cycles, `aborted` pulses once and `busy` falls.
- R9: After an abort the same byte is sent again, as a complete frame, once the link has been free for HALF_CYC cycles.
- R10: Host contention during the high phase before the 11th clock (that is, after the tenth rising edge) is ignored. The frame completes with `done` and without `aborted`.
- R11: `done` is a one-cycle pulse following the 11th clock's rising edge. `busy` is high from the start of the frame and falls only together with `done` or `aborted`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | Upstream offers a byte |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Block can take a byte |
| ps2_clk_in | input | 1 | Sampled level of the CLK wire |
| ps2_data_in | input | 1 | Sampled level of the DATA wire |
| ps2_clk_drv_low | output | 1 | Pull the CLK wire low |
| ps2_data_drv_low | output | 1 | Pull the DATA wire low |
| busy | output | 1 | A frame attempt is in progress |
| done | output | 1 | One-cycle pulse: frame completed |
| aborted | output | 1 | One-cycle pulse: attempt lost to host contention |

## Verification
The frame encoder is swept over all 256 byte values. This covers every parity outcome and every position of each data bit, so a swapped bit order, an inverted parity or a missing start or stop bit each gives a wrong captured word. Host contention is injected in each of the ten high phases that permit an abort, and then in the high phase just after that window. This separates an off-by-one abort boundary from a correct one and confirms that the retried frame carries the held byte. Inhibit and request-to-send are applied before a byte is offered, which shows that the link-free qualification holds back the start in both cases. The bench also measures the delay from release to start.

// File: rtl/ps2_tx_pkg.sv
package ps2_tx_pkg;

  typedef enum logic [1:0] {
    PH_WAIT = 2'd0,
    PH_HIGH = 2'd1,
    PH_LOW  = 2'd2
  } ph_t;

  // bits per frame and the last bit whose high phase may still be aborted
  localparam int FRAME_LEN  = 11;
  localparam int LAST_ABORT = 9;
  // cycles for a released CLK to show up through the input synchroniser
  localparam int SYNC_SKIP  = 2;

  function automatic logic odd_par(input logic [7:0] b);
    return ~^b;
  endfunction

  // bit k of the result is the k-th bit on the wire
  function automatic logic [FRAME_LEN-1:0] build_frame(input logic [7:0] b);
    return {1'b1, odd_par(b), b, 1'b0};
  endfunction

endpackage

// File: rtl/ps2_half_timer.sv
module ps2_half_timer #(
  parameter int HALF_CYC = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  output logic [$clog2(HALF_CYC)-1:0] cnt,
  output logic                        last
);
  localparam int CW = $clog2(HALF_CYC);

  assign last = (cnt == CW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (last)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HALF_CYC - 1)); // R6

endmodule

// File: rtl/ps2_line_mon.sv
module ps2_line_mon #(
  parameter int IDLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_in,
  input  logic data_in,
  output logic clk_s,
  output logic lines_idle
);
  localparam int IW = $clog2(IDLE_CYC + 1);

  logic [1:0]    clk_sync, dat_sync;
  logic          data_s;
  logic [IW-1:0] idle_cnt;

  assign clk_s  = clk_sync[1];
  assign data_s = dat_sync[1];
  assign lines_idle = (idle_cnt == IW'(IDLE_CYC)) && clk_s && data_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_sync <= '0;
      dat_sync <= '0;
      idle_cnt <= '0;
    end else begin
      clk_sync <= {clk_sync[0], clk_in};
      dat_sync <= {dat_sync[0], data_in};
      if (!(clk_s && data_s))             idle_cnt <= '0;
      else if (idle_cnt != IW'(IDLE_CYC)) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  AST_IDLE_SEEN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    lines_idle |-> $past(clk_s) && $past(data_s)); // R3

endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx #(
  parameter int HALF_CYC = 3125  // half-period in clk cycles, at least 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready,
  input  logic       ps2_clk_in,
  input  logic       ps2_data_in,
  output logic       ps2_clk_drv_low,
  output logic       ps2_data_drv_low,
  output logic       busy,
  output logic       done,
  output logic       aborted
);
  import ps2_tx_pkg::*;

  localparam int CW  = $clog2(HALF_CYC);
  localparam int MID = HALF_CYC / 2;

  ph_t                  phase;
  logic [3:0]           bit_idx;
  logic                 out_bit;
  logic                 have_byte;
  logic [7:0]           hold_byte;
  logic                 done_q, abort_q;
  logic [CW-1:0]        cnt;
  logic                 last;
  logic                 clk_s, lines_idle;
  logic [FRAME_LEN-1:0] frame_bits;

  // named events for the assertions
  logic accept, start_go, contention, frame_end, at_mid, check_win, tmr_clr;

  assign frame_bits = build_frame(hold_byte);
  assign accept     = tx_valid && !have_byte;
  assign start_go   = (phase == PH_WAIT) && have_byte && lines_idle;
  assign at_mid     = (cnt == CW'(MID));
  assign check_win  = (phase == PH_HIGH) && (bit_idx <= 4'(LAST_ABORT))
                      && (cnt >= CW'(SYNC_SKIP));
  assign contention = check_win && !clk_s;
  assign frame_end  = (phase == PH_LOW) && last && (bit_idx == 4'(FRAME_LEN - 1));
  assign tmr_clr    = (phase == PH_WAIT) || contention;

  ps2_line_mon #(.IDLE_CYC(HALF_CYC)) u_mon (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_in     (ps2_clk_in),
    .data_in    (ps2_data_in),
    .clk_s      (clk_s),
    .lines_idle (lines_idle)
  );

  ps2_half_timer #(.HALF_CYC(HALF_CYC)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .cnt   (cnt),
    .last  (last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_WAIT;
      bit_idx   <= '0;
      out_bit   <= 1'b1;
      have_byte <= 1'b0;
      hold_byte <= '0;
      done_q    <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      done_q  <= frame_end;
      abort_q <= contention;
      if (accept) begin
        have_byte <= 1'b1;
        hold_byte <= tx_data;
      end else if (frame_end) begin
        have_byte <= 1'b0;
      end
      unique case (phase)
        PH_WAIT: if (start_go) begin
          phase   <= PH_HIGH;
          bit_idx <= '0;
        end
        PH_HIGH: begin
          if (contention) begin
            phase   <= PH_WAIT;
            out_bit <= 1'b1;
          end else begin
            if (at_mid) out_bit <= frame_bits[bit_idx];
            if (last)   phase   <= PH_LOW;
          end
        end
        PH_LOW: if (last) begin
          if (bit_idx == 4'(FRAME_LEN - 1)) begin
            phase   <= PH_WAIT;
            out_bit <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            phase   <= PH_HIGH;
          end
        end
        default: phase <= PH_WAIT;
      endcase
    end
  end

  assign tx_ready         = !have_byte;
  assign busy             = (phase != PH_WAIT);
  assign ps2_clk_drv_low  = (phase == PH_LOW);
  assign ps2_data_drv_low = busy && !out_bit;
  assign done             = done_q;
  assign aborted          = abort_q;

  AST_START_ON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(lines_idle)); // R3
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    ps2_clk_drv_low && $past(ps2_clk_drv_low) |-> $stable(ps2_data_drv_low)); // R7
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> !ps2_clk_drv_low && !ps2_data_drv_low && !busy); // R8
  AST_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    aborted |-> !tx_ready); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> tx_ready && !aborted); // R2

endmodule

// File: tb/ps2_dev_tx_test.sv
module ps2_dev_tx_test;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_ready, dut_clk_low, dut_data_low, busy, done, aborted;
  logic host_clk_low = 1'b0;
  logic host_data_low = 1'b0;
  logic line_clk, line_data;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;  // 125 MHz

  assign line_clk  = !(dut_clk_low | host_clk_low);
  assign line_data = !(dut_data_low | host_data_low);

  ps2_dev_tx #(.HALF_CYC(HALF)) uut (
    .clk              (clk),
    .rst_n            (rst_n),
    .tx_valid         (tx_valid),
    .tx_data          (tx_data),
    .tx_ready         (tx_ready),
    .ps2_clk_in       (line_clk),
    .ps2_data_in      (line_data),
    .ps2_clk_drv_low  (dut_clk_low),
    .ps2_data_drv_low (dut_data_low),
    .busy             (busy),
    .done             (done),
    .aborted          (aborted)
  );

  // line monitor: decodes frames and times phases
  int fall_total = 0, done_total = 0, abort_total = 0;
  int phase_bad = 0, dchg_bad = 0, busy_bad = 0;
  int lo_run = 0, hi_run = 0;
  logic [10:0] rx_sh = '0;
  logic pclk = 1'b0, pdat = 1'b0, pbusy = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!pclk && dut_clk_low) begin
        rx_sh <= {!dut_data_low, rx_sh[10:1]};
        fall_total <= fall_total + 1;
        if (hi_run != HALF) phase_bad <= phase_bad + 1;
      end
      if (pclk && !dut_clk_low && lo_run != HALF) phase_bad <= phase_bad + 1;
      if ((dut_data_low != pdat) && (dut_clk_low || pclk)) dchg_bad <= dchg_bad + 1;
      if (pbusy && !busy && !done && !aborted) busy_bad <= busy_bad + 1;
      if (done) done_total <= done_total + 1;
      if (aborted) abort_total <= abort_total + 1;
      lo_run <= dut_clk_low ? lo_run + 1 : 0;
      hi_run <= (dut_clk_low || !busy) ? 0 : hi_run + 1;
    end
    pclk  <= dut_clk_low;
    pdat  <= dut_data_low;
    pbusy <= busy;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [10:0] exp_frame(input logic [7:0] b);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(b[i]);
    return {1'b1, (ones % 2 == 0) ? 1'b1 : 1'b0, b, 1'b0};
  endfunction

  task automatic offer(input logic [7:0] b);
    int g = 0;
    @(negedge clk);
    while (!tx_ready && g < 5000) begin @(negedge clk); g++; end
    tx_valid = 1'b1;
    tx_data  = b;
    @(negedge clk);
    tx_valid = 1'b0;
    chk(tx_ready == 1'b0, "R2 ready drops", int'(tx_ready), 0);
  endtask

  task automatic wait_done(input int d0);
    int g = 0;
    while (done_total == d0 && g < 4000) begin @(negedge clk); g++; end
    @(negedge clk);
  endtask

  task automatic check_frame(input logic [7:0] b, input int f0, input int d0,
                             input int a0, input string req);
    chk(fall_total - f0 == 11, req, fall_total - f0, 11);
    chk(rx_sh == exp_frame(b), req, int'(rx_sh), int'(exp_frame(b)));
    chk(done_total == d0 + 1 && abort_total == a0, req, done_total - d0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int f0, d0, a0, t;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_ready && !busy && !done && !aborted && !dut_clk_low && !dut_data_low,
        "R1 reset state", {tx_ready, busy, done, aborted, dut_clk_low, dut_data_low}, 6'b100000);

    // R3 inhibit, then release-to-start delay
    host_clk_low = 1'b1;
    f0 = fall_total; d0 = done_total; a0 = abort_total;
    offer(8'hA5);
    repeat (40) @(negedge clk);
    chk(!busy && !dut_clk_low && !dut_data_low, "R3 inhibit holds", int'(busy), 0);
    host_clk_low = 1'b0;
    t = 0;
    while (!busy && t < 100) begin @(negedge clk); t++; end
    chk(t >= HALF && t <= HALF + 4, "R3 start delay", t, HALF);
    wait_done(d0);
    check_frame(8'hA5, f0, d0, a0, "R3 frame after inhibit");

    // R4 request-to-send blocks start
    host_data_low = 1'b1;
    f0 = fall_total; d0 = done_total; a0 = abort_total;
    offer(8'h5A);
    repeat (40) @(negedge clk);
    chk(!busy && !dut_clk_low, "R4 rts holds", int'(busy), 0);
    host_data_low = 1'b0;
    wait_done(d0);
    check_frame(8'h5A, f0, d0, a0, "R4 frame after rts");

    // R5 R11: every byte value
    for (int b = 0; b < 256; b++) begin
      f0 = fall_total; d0 = done_total; a0 = abort_total;
      offer(8'(b));
      wait_done(d0);
      check_frame(8'(b), f0, d0, a0, "R5 frame sweep");
      chk(!busy && tx_ready, "R11 idle after done", int'(busy), 0);
    end

    // R8 R9: contention in each abortable high phase
    for (int k = 0; k < 10; k++) begin
      logic [7:0] v;
      v = 8'h3C ^ 8'(k * 37);
      f0 = fall_total; d0 = done_total; a0 = abort_total;
      offer(v);
      t = 0;
      while (!(busy && !dut_clk_low && fall_total - f0 == k) && t < 2000) begin
        @(negedge clk); t++;
      end
      repeat (3) @(negedge clk);
      host_clk_low = 1'b1;
      repeat (4) @(negedge clk);
      chk(!dut_clk_low && !dut_data_low && !busy, "R8 release on contention",
          {dut_clk_low, dut_data_low, busy}, 0);
      chk(abort_total == a0 + 1 && done_total == d0, "R8 abort pulse", abort_total - a0, 1);
      chk(!tx_ready, "R9 byte held", int'(tx_ready), 0);
      repeat (30) @(negedge clk);
      chk(!busy && !dut_clk_low, "R3 no start while inhibited", int'(busy), 0);
      f0 = fall_total;
      host_clk_low = 1'b0;
      wait_done(d0);
      check_frame(v, f0, d0, a0 + 1, "R9 retry frame");
    end

    // R10: contention after the tenth rising edge
    f0 = fall_total; d0 = done_total; a0 = abort_total;
    offer(8'hC3);
    t = 0;
    while (!(busy && !dut_clk_low && fall_total - f0 == 10) && t < 2000) begin
      @(negedge clk); t++;
    end
    repeat (3) @(negedge clk);
    host_clk_low = 1'b1;
    wait_done(d0);
    host_clk_low = 1'b0;
    check_frame(8'hC3, f0, d0, a0, "R10 late contention ignored");

    repeat (20) @(negedge clk);
    chk(phase_bad == 0, "R6 phase lengths", phase_bad, 0);
    chk(dchg_bad == 0, "R7 data change timing", dchg_bad, 0);
    chk(busy_bad == 0, "R11 busy end", busy_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule